// File: doc/BRIEF.md
# Segmented Multi-Ring Transfer Arbiter

Central arbiter for an on-chip interconnect made of several one-way rings that join a fixed set of nodes. Each node presents one request at a time, carrying a target node and a transfer length in beats. The arbiter places each request it grants on a ring that runs the short way round and that has none of the new path's segments in use. The ring's segments stay reserved for as long as the transfer needs them. The arbiter does not move any data. Its only job is to set up the path before any data moves. A ring works as a bus that can be split into pieces, so one ring carries several transfers at once on spans that do not overlap.

A requester holds its request until it sees a grant or an error pulse for its own node, and drops it in the following cycle. Every reservation is tracked inside the arbiter from the transfer length. Each ring has a done pulse that marks the cycle in which segments come free.

Top module: `ring_xfer_arbiter`

## Requirements
- R1: A request is legal only when its target is below 12, differs from the requesting node, and its length field (in beats, 16 bytes each) lies in 1..8. An illegal request gets a one-cycle `err_o` pulse on its node's bit in the cycle after it is sampled, and it is never granted.
- R2: The clockwise hop count is h = (dst - src) mod 12. For h < 6 only rings 0 and 1 may be used. These are the clockwise rings, on which segment k joins node k to node k+1, and the path uses segments src..dst-1. For h > 6 only rings 2 and 3 may be used. These are the counter-clockwise rings, on which segment k joins node k+1 to node k, and the path uses segments dst..src-1. For h = 6 any ring may be used.
- R3: A grant goes only to a ring on which no segment of the new path is busy and which carries fewer than 3 transfers.
- R4: Among the rings that qualify, the one with the lowest index is chosen, and it is reported on `gnt_ring_o` alongside the grant.
- R5: At most one grant is issued per cycle. A grant is a one-cycle pulse that appears in the cycle after the request was sampled.
- R6: Node 0, the memory-controller node, is granted whenever its request can be placed, ahead of every other request.
- R7: The other nodes are served in round-robin order. After node i is granted, the search for the next winner begins at node i+1 and wraps around; node 0 is skipped.
- R8: A transfer of L beats shows its segments in `seg_busy_o` (ring r at bits r*12 .. r*12+11) for 2*L cycles, beginning with the grant cycle. In the cycle after that, the segments read free and the ring's `done_o` bit pulses. A request that overlaps them can be granted from the next edge.
- R9: While reset is asserted and just after it is released, no grant, error, busy segment or done pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 12 | Request valid, one bit per node |
| req_dst_i | input | 48 | Target node, 4 bits per node |
| req_len_i | input | 48 | Length in beats, 4 bits per node |
| gnt_o | output | 12 | Grant pulse, one bit per node |
| gnt_ring_o | output | 2 | Ring picked for the current grant |
| err_o | output | 12 | Reject pulse for an illegal request |
| seg_busy_o | output | 48 | Busy segments, 12 bits per ring |
| done_o | output | 4 | Pulses when a ring frees segments |

## Verification
Directed cases each target one behaviour. Short clockwise paths and paths that wrap counter-clockwise show whether ring direction and segment masks are right. Simultaneous requests from the memory node and another node show priority. Four disjoint one-hop transfers issued together show the per-ring transfer limit, as opposed to the overlap rule. Self-targeted, zero-length and over-long requests show rejection. A single transfer watched until its segments clear pins the release cycle. A long random run then mixes legal and illegal requests of all lengths and hop counts, including exact half-ring paths. This piles up contention, so round-robin order, ring fallback and slot reuse are compared every cycle against a reference model.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  localparam int unsigned MAX_NODES = 32;
  typedef logic [MAX_NODES-1:0] seg_vec_t;

  // contiguous run of segments starting at first, wrapping at nodes
  function automatic seg_vec_t span_mask(input int unsigned first, input int unsigned hops,
                                         input int unsigned nodes);
    seg_vec_t m;
    m = '0;
    for (int unsigned k = 0; k < MAX_NODES; k++)
      if (k < hops) m[5'((first + k) % nodes)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ring_path_calc.sv
module ring_path_calc
  import ring_arb_pkg::*;
#(
  parameter int unsigned N         = 12,
  parameter int unsigned NW        = 4,
  parameter int unsigned LW        = 4,
  parameter int unsigned MAX_BEATS = 8,
  parameter int unsigned SRC       = 0
) (
  input  logic [NW-1:0] dst_i,
  input  logic [LW-1:0] len_i,
  output logic          legal_o,
  output logic          cw_ok_o,
  output logic          ccw_ok_o,
  output logic [N-1:0]  cw_mask_o,
  output logic [N-1:0]  ccw_mask_o
);
  int unsigned d, hcw, hccw;
  seg_vec_t    mcw, mccw;

  always_comb begin
    d        = int'(dst_i);
    hcw      = (d + N - SRC) % N;
    hccw     = N - hcw;
    legal_o  = (d < N) && (d != SRC) && (len_i != '0) && (int'(len_i) <= MAX_BEATS);
    cw_ok_o  = legal_o && (2 * hcw <= N);
    ccw_ok_o = legal_o && (2 * hccw <= N);
    mcw      = span_mask(SRC, hcw, N);
    mccw     = span_mask(d % N, hccw, N);
    cw_mask_o  = mcw[N-1:0];
    ccw_mask_o = mccw[N-1:0];
  end
endmodule

// File: rtl/ring_track.sv
module ring_track #(
  parameter int unsigned N     = 12,
  parameter int unsigned SLOTS = 3,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N-1:0]  mask_i,
  input  logic [CW-1:0] cnt_i,
  output logic [N-1:0]  busy_o,
  output logic          room_o,
  output logic          done_o
);
  logic [SLOTS-1:0] act_q, pick, fin;
  logic [CW-1:0]    cnt_q  [SLOTS];
  logic [N-1:0]     mask_q [SLOTS];
  logic             found;

  always_comb begin
    pick   = '0;
    found  = 1'b0;
    busy_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!act_q[s] && !found) begin
        pick[s] = 1'b1;
        found   = 1'b1;
      end
      if (act_q[s]) busy_o = busy_o | mask_q[s];
      fin[s] = act_q[s] && (cnt_q[s] == CW'(1));
    end
    room_o = ~&act_q;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[s]  <= 1'b0;
        cnt_q[s]  <= '0;
        mask_q[s] <= '0;
      end else if (load_i && pick[s]) begin
        act_q[s]  <= 1'b1;
        cnt_q[s]  <= cnt_i;
        mask_q[s] <= mask_i;
      end else if (act_q[s]) begin
        cnt_q[s] <= cnt_q[s] - 1'b1;
        if (fin[s]) act_q[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= |fin;
  end
endmodule

// File: rtl/ring_arb_pick.sv
module ring_arb_pick #(
  parameter int unsigned N         = 12,
  parameter int unsigned IW        = 4,
  parameter int unsigned PRIO_NODE = 0
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] rr_i,
  output logic          win_o,
  output logic [IW-1:0] win_idx_o
);
  int unsigned idx;

  always_comb begin
    win_o     = 1'b0;
    win_idx_o = '0;
    idx       = 0;
    if (cand_i[PRIO_NODE]) begin
      win_o     = 1'b1;
      win_idx_o = IW'(PRIO_NODE);
    end else begin
      for (int unsigned k = 0; k < N; k++) begin
        idx = (int'(rr_i) + k) % N;
        if (!win_o && idx != PRIO_NODE && cand_i[idx]) begin
          win_o     = 1'b1;
          win_idx_o = IW'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/ring_xfer_arbiter.sv
module ring_xfer_arbiter #(
  parameter int unsigned N_NODES      = 12,
  parameter int unsigned N_RINGS      = 4,
  parameter int unsigned SLOTS        = 3,
  parameter int unsigned MAX_BEATS    = 8,
  parameter int unsigned CLK_PER_BEAT = 2,
  parameter int unsigned PRIO_NODE    = 0,
  localparam int unsigned NW = $clog2(N_NODES),
  localparam int unsigned LW = $clog2(MAX_BEATS + 1),
  localparam int unsigned RW = (N_RINGS > 1) ? $clog2(N_RINGS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_NODES-1:0]       req_i,
  input  logic [N_NODES*NW-1:0]    req_dst_i,
  input  logic [N_NODES*LW-1:0]    req_len_i,
  output logic [N_NODES-1:0]       gnt_o,
  output logic [RW-1:0]            gnt_ring_o,
  output logic [N_NODES-1:0]       err_o,
  output logic [N_RINGS*N_NODES-1:0] seg_busy_o,
  output logic [N_RINGS-1:0]       done_o
);
  localparam int unsigned CW   = $clog2(MAX_BEATS * CLK_PER_BEAT + 1);
  localparam int unsigned HALF = N_RINGS / 2;

  logic [N_NODES-1:0] legal, cw_ok, ccw_ok, cand;
  logic [N_NODES-1:0] cw_mask  [N_NODES];
  logic [N_NODES-1:0] ccw_mask [N_NODES];
  logic [N_NODES-1:0] busy     [N_RINGS];
  logic [N_RINGS-1:0] fits     [N_NODES];
  logic [N_RINGS-1:0] room, load;
  logic               win;
  logic [NW-1:0]      win_idx, rr_q;
  logic [RW-1:0]      win_ring;
  logic [N_NODES-1:0] load_mask;
  logic [CW-1:0]      load_cnt;
  logic [N_NODES-1:0] gnt_q, err_q;
  logic [RW-1:0]      ring_q;

  for (genvar i = 0; i < N_NODES; i++) begin : g_node
    ring_path_calc #(
      .N(N_NODES), .NW(NW), .LW(LW), .MAX_BEATS(MAX_BEATS), .SRC(i)
    ) u_path (
      .dst_i     (req_dst_i[i*NW +: NW]),
      .len_i     (req_len_i[i*LW +: LW]),
      .legal_o   (legal[i]),
      .cw_ok_o   (cw_ok[i]),
      .ccw_ok_o  (ccw_ok[i]),
      .cw_mask_o (cw_mask[i]),
      .ccw_mask_o(ccw_mask[i])
    );
  end

  // ring r < HALF runs clockwise, the rest counter-clockwise
  always_comb begin
    for (int i = 0; i < N_NODES; i++) begin
      for (int r = 0; r < N_RINGS; r++) begin
        if (r < HALF)
          fits[i][r] = req_i[i] && cw_ok[i] && room[r] && ((cw_mask[i] & busy[r]) == '0);
        else
          fits[i][r] = req_i[i] && ccw_ok[i] && room[r] && ((ccw_mask[i] & busy[r]) == '0);
      end
      cand[i] = |fits[i];
    end
  end

  ring_arb_pick #(.N(N_NODES), .IW(NW), .PRIO_NODE(PRIO_NODE)) u_pick (
    .cand_i   (cand),
    .rr_i     (rr_q),
    .win_o    (win),
    .win_idx_o(win_idx)
  );

  always_comb begin
    win_ring = '0;
    for (int r = N_RINGS - 1; r >= 0; r--)
      if (fits[win_idx][r]) win_ring = RW'(r);
    load_mask = (int'(win_ring) < HALF) ? cw_mask[win_idx] : ccw_mask[win_idx];
    load_cnt  = CW'(int'(req_len_i[win_idx*LW +: LW]) * CLK_PER_BEAT);
    for (int r = 0; r < N_RINGS; r++) load[r] = win && (win_ring == RW'(r));
  end

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    ring_track #(.N(N_NODES), .SLOTS(SLOTS), .CW(CW)) u_track (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load[r]),
      .mask_i(load_mask),
      .cnt_i (load_cnt),
      .busy_o(busy[r]),
      .room_o(room[r]),
      .done_o(done_o[r])
    );
    assign seg_busy_o[r*N_NODES +: N_NODES] = busy[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      err_q  <= '0;
      ring_q <= '0;
      rr_q   <= '0;
    end else begin
      gnt_q  <= win ? (N_NODES'(1) << win_idx) : '0;
      err_q  <= req_i & ~legal;
      ring_q <= win_ring;
      if (win && win_idx != NW'(PRIO_NODE))
        rr_q <= (win_idx == NW'(N_NODES - 1)) ? '0 : win_idx + 1'b1;
    end
  end

  assign gnt_o      = gnt_q;
  assign err_o      = err_q;
  assign gnt_ring_o = ring_q;
endmodule

// File: rtl/ring_xfer_arbiter_chk.sv
module ring_xfer_arbiter_chk #(
  parameter int unsigned N_NODES = 12,
  parameter int unsigned N_RINGS = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_NODES-1:0]           req_i,
  input logic [N_NODES-1:0]           gnt_o,
  input logic [N_NODES-1:0]           err_o,
  input logic [N_RINGS*N_NODES-1:0]   seg_busy_o,
  input logic [N_RINGS-1:0]           done_o
);
  assert_one_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_grant_had_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> ((gnt_o & $past(req_i)) != '0));

  assert_no_grant_on_err_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & err_o) == '0);

  assert_err_had_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_o) |-> ((err_o & ~$past(req_i)) == '0));

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    assert_release_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(seg_busy_o[r*N_NODES +: N_NODES]) & ~seg_busy_o[r*N_NODES +: N_NODES]) != '0)
        |-> done_o[r]);

    assert_done_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[r] |->
        (($past(seg_busy_o[r*N_NODES +: N_NODES]) & ~seg_busy_o[r*N_NODES +: N_NODES]) != '0));
  end
endmodule

bind ring_xfer_arbiter ring_xfer_arbiter_chk #(
  .N_NODES(N_NODES), .N_RINGS(N_RINGS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .gnt_o     (gnt_o),
  .err_o     (err_o),
  .seg_busy_o(seg_busy_o),
  .done_o    (done_o)
);

// File: tb/sim_ring_xfer_arbiter.sv
`timescale 1ns/1ps
module sim_ring_xfer_arbiter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] req_i;
  logic [47:0] req_dst_i, req_len_i;
  logic [11:0] gnt_o, err_o;
  logic [1:0]  gnt_ring_o;
  logic [47:0] seg_busy_o;
  logic [3:0]  done_o;

  ring_xfer_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_dst_i(req_dst_i),
    .req_len_i(req_len_i), .gnt_o(gnt_o), .gnt_ring_o(gnt_ring_o),
    .err_o(err_o), .seg_busy_o(seg_busy_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;
  bit pend [12];
  int pdst [12], plen [12];
  int rem  [4][3];
  logic [11:0] smask [4][3];
  int rr = 0;

  always_comb
    for (int i = 0; i < 12; i++) begin
      req_i[i]            = pend[i];
      req_dst_i[i*4 +: 4] = 4'(pdst[i]);
      req_len_i[i*4 +: 4] = 4'(plen[i]);
    end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] walk(int s, int d, bit cw);
    logic [11:0] m = '0;
    int p = s;
    while (p != d) begin
      if (cw) begin m[p] = 1'b1; p = (p + 1) % 12; end
      else begin p = (p + 11) % 12; m[p] = 1'b1; end
    end
    return m;
  endfunction

  function automatic logic [11:0] ring_busy(int r);
    logic [11:0] b = '0;
    for (int s = 0; s < 3; s++) if (rem[r][s] > 0) b |= smask[r][s];
    return b;
  endfunction

  // reference placement: lowest ring whose direction fits and which has room
  function automatic int place(int i);
    int h, n;
    bit cw;
    if (!pend[i] || pdst[i] >= 12 || pdst[i] == i || plen[i] < 1 || plen[i] > 8) return -1;
    h = (pdst[i] - i + 12) % 12;
    for (int r = 0; r < 4; r++) begin
      cw = (r < 2);
      if ((cw && h > 6) || (!cw && h < 6)) continue;
      n = 0;
      for (int s = 0; s < 3; s++) if (rem[r][s] > 0) n++;
      if (n < 3 && (walk(i, pdst[i], cw) & ring_busy(r)) == '0) return r;
    end
    return -1;
  endfunction

  task automatic step();
    int eg = -1, er = -1, fr, slot, idx;
    logic [11:0] ee = '0;
    logic [3:0]  edn = '0;
    logic [47:0] eb;
    for (int i = 0; i < 12; i++)
      if (pend[i] && (pdst[i] >= 12 || pdst[i] == i || plen[i] < 1 || plen[i] > 8)) ee[i] = 1'b1;
    fr = place(0);
    if (fr >= 0) begin eg = 0; er = fr; end
    else
      for (int k = 0; k < 12; k++) begin
        idx = (rr + k) % 12;
        if (eg < 0 && idx != 0 && place(idx) >= 0) begin eg = idx; er = place(idx); end
      end
    @(posedge clk); #1;
    slot = -1;
    if (eg >= 0)
      for (int s = 2; s >= 0; s--) if (rem[er][s] == 0) slot = s;
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 3; s++)
        if (rem[r][s] > 0) begin
          if (rem[r][s] == 1) edn[r] = 1'b1;
          rem[r][s]--;
        end
    if (eg >= 0) begin
      rem[er][slot]   = 2 * plen[eg];
      smask[er][slot] = walk(eg, pdst[eg], er < 2);
      if (eg != 0) rr = (eg + 1) % 12;
    end
    for (int r = 0; r < 4; r++) eb[r*12 +: 12] = ring_busy(r);
    chk(eg == 0 ? "R6 grant" : "R7 grant", gnt_o, eg >= 0 ? (64'd1 << eg) : 64'd0);
    if (eg >= 0) chk("R4 ring", gnt_ring_o, er);
    chk("R1 err", err_o, ee);
    chk("R3 busy", seg_busy_o, eb);
    chk("R8 done", done_o, edn);
    if (eg >= 0) pend[eg] = 0;
    for (int i = 0; i < 12; i++) if (ee[i]) pend[i] = 0;
  endtask

  task automatic ask(int i, int d, int l);
    pend[i] = 1; pdst[i] = d; plen[i] = l;
  endtask

  task automatic drain();
    for (int n = 0; n < 200; n++) begin
      bit idle = 1;
      for (int i = 0; i < 12; i++) if (pend[i]) idle = 0;
      for (int r = 0; r < 4; r++) for (int s = 0; s < 3; s++) if (rem[r][s] > 0) idle = 0;
      if (idle) break;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    for (int i = 0; i < 12; i++) begin pend[i] = 0; pdst[i] = 0; plen[i] = 0; end
    for (int r = 0; r < 4; r++) for (int s = 0; s < 3; s++) begin rem[r][s] = 0; smask[r][s] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R9 gnt", gnt_o, 0);
    chk("R9 err", err_o, 0);
    chk("R9 busy", seg_busy_o, 0);
    chk("R9 done", done_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    step();
    chk("R9 idle", {gnt_o, err_o, seg_busy_o[11:0], done_o}, 0);

    // R2: clockwise short path
    ask(2, 5, 1); step();
    chk("R2 cw ring", gnt_ring_o, 0);
    chk("R2 cw segs", seg_busy_o[11:0], 12'h01C);
    drain();
    // R2: counter-clockwise wrap path
    ask(5, 1, 1); step();
    chk("R2 ccw ring", gnt_ring_o, 2);
    chk("R2 ccw segs", seg_busy_o[35:24], 12'h01E);
    drain();
    // R6: memory node beats a simultaneous request
    ask(7, 8, 1); ask(0, 1, 1); step();
    chk("R6 first", gnt_o, 12'h001);
    step();
    chk("R7 second", gnt_o, 12'h080);
    drain();
    // R3: three transfers fill ring 0, fourth falls back to ring 1
    ask(1, 2, 8); ask(3, 4, 8); ask(5, 6, 8); ask(7, 8, 8);
    step(); step(); step(); step();
    chk("R3 slot limit", gnt_ring_o, 1);
    drain();
    // R1: illegal requests are rejected
    ask(4, 4, 2); ask(6, 9, 0); ask(8, 2, 9); step();
    chk("R1 reject", err_o, 12'h150);
    chk("R1 no grant", gnt_o, 0);
    drain();
    // R8: 2-beat transfer holds its segment 4 cycles
    ask(3, 4, 2); step();
    chk("R8 held", seg_busy_o[3], 1);
    step(); step(); step();
    chk("R8 still held", seg_busy_o[3], 1);
    step();
    chk("R8 released", seg_busy_o[3], 0);
    chk("R8 done pulse", done_o[0], 1);
    drain();

    for (int c = 0; c < 4000; c++) begin
      step();
      for (int i = 0; i < 12; i++)
        if (!pend[i] && $urandom_range(0, 5) == 0)
          ask(i, $urandom_range(0, 12), $urandom_range(0, 9));
    end
    for (int i = 0; i < 12; i++) pend[i] = 0;
    drain();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule